// File: doc/BRIEF.md
# Compact Float Immediate Loader

This block builds 64-bit double-precision register values from 16-bit immediates. A load operation takes the immediate as the upper half of a single-precision bit pattern, fills the lower half with zeros, widens the result to double precision and writes it out. An insert operation takes the current 64-bit register value, narrows it to single precision, keeps the upper sixteen bits of that single pattern, puts the new immediate in the lower sixteen bits, widens the result back to double and writes it to the same register. Issuing a load followed by an insert therefore yields any single-precision constant, held in double format.

The immediate comes in three instruction fields. The register file and the instruction decode sit outside the block. The caller supplies the current register value on `reg_i`, and after one register stage the block returns the new value together with a write strobe. Neither operation produces condition or status output.

Top module: `fp_imm_loader`

## Requirements
- R1: The 16-bit immediate is `{imm_hi_i, imm_mid_i, imm_lo_i}`. `imm_hi_i` (10 bits) forms bits 15..6, `imm_mid_i` (5 bits) forms bits 5..1 and `imm_lo_i` forms bit 0.
- R2: With `op_i`=0 (load), the result is the single pattern `{imm,16'h0000}` widened to double: exponent rebiased by +896 and the fraction padded with 29 zeros. For example, 0x0000 gives 0x0, 0x8000 gives 0x8000000000000000, 0x3F80 gives 0x3FF0000000000000, 0xBF80 gives 0xBFF0000000000000, 0xBFC0 gives 0xBFF8000000000000 and 0x3FFF gives 0x3FFFE00000000000.
- R3: A single exponent of all ones widens to the double exponent 0x7FF with the fraction kept in the top bits. 0x7F80 gives 0x7FF0000000000000, 0xFF80 gives 0xFFF0000000000000 and 0x7FC0 gives the quiet NaN 0x7FF8000000000000.
- R4: A single subnormal widens to a normal double. Example: 0x0001 gives 0x37A0000000000000, 0x0002 gives 0x37B0000000000000 and 0x8040 gives 0xB800000000000000.
- R5: With `op_i`=1 (insert), the result is the widening of `{narrow(reg_i)[31:16], imm}`. For example, reg 0x3FF0000000000000 with imm 0x8000 gives 0x3FF0100000000000.
- R6: Narrowing drops double fraction bits below single precision without rounding. A double exponent below the smallest single subnormal narrows to a signed zero. A finite double above the single range narrows to a signed infinity.
- R7: Narrowing a double NaN whose upper 23 fraction bits are zero sets single fraction bit 22, so the value stays a NaN. Example: reg 0x7FF0000000000001 with imm 0x0000 gives 0x7FF8000000000000.
- R8: `wr_en_o` is high for exactly the one cycle after each cycle with `valid_i` high. `result_o` changes only together with `wr_en_o`. Reset clears both to zero.
- R9: Operations can be accepted on consecutive cycles. An insert whose `reg_i` is the previous result, taken in the cycle that result's strobe is high, combines correctly with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Accept an operation this cycle |
| op_i | input | 1 | 0 = load, 1 = insert |
| imm_hi_i | input | 10 | Immediate bits 15..6 |
| imm_mid_i | input | 5 | Immediate bits 5..1 |
| imm_lo_i | input | 1 | Immediate bit 0 |
| reg_i | input | 64 | Current destination register value (read by insert) |
| result_o | output | 64 | New register value |
| wr_en_o | output | 1 | Register write strobe |

## Verification
Two things can happen in the same cycle: the write strobe of a load and the acceptance of an insert that must read the value being written. The bench provokes this by keeping `valid_i` high across two cycles. In the second cycle it switches `op_i` to insert and feeds the `result_o` just produced into `reg_i`. The check passes if the strobe stays high for exactly two cycles and the second result equals the combined constant 0x3FF0100000000000.

// File: rtl/fli_pkg.sv
package fli_pkg;
  localparam int SP_W       = 32;
  localparam int SP_EXP_W   = 8;
  localparam int SP_FRAC_W  = 23;
  localparam int DP_W       = 64;
  localparam int DP_EXP_W   = 11;
  localparam int DP_FRAC_W  = 52;
  localparam int FRAC_PAD_W = DP_FRAC_W - SP_FRAC_W;
  localparam int SP_BIAS    = 127;
  localparam int DP_BIAS    = 1023;
  localparam int BIAS_DIFF  = DP_BIAS - SP_BIAS;
  localparam int HALF_W     = SP_W / 2;

  typedef enum logic {
    OP_LOAD   = 1'b0,
    OP_INSERT = 1'b1
  } fli_op_e;
endpackage

// File: rtl/fli_imm_join.sv
module fli_imm_join #(
  parameter int HI_W  = 10,
  parameter int MID_W = 5,
  parameter int LO_W  = 1,
  localparam int IMM_W = HI_W + MID_W + LO_W
) (
  input  logic [HI_W-1:0]  hi_i,
  input  logic [MID_W-1:0] mid_i,
  input  logic [LO_W-1:0]  lo_i,
  output logic [IMM_W-1:0] imm_o
);
  assign imm_o = {hi_i, mid_i, lo_i};
endmodule

// File: rtl/fli_sp2dp.sv
module fli_sp2dp
  import fli_pkg::*;
(
  input  logic [SP_W-1:0] sp_i,
  output logic [DP_W-1:0] dp_o
);
  localparam int LZ_W = $clog2(SP_FRAC_W + 1);

  logic                 sgn;
  logic [SP_EXP_W-1:0]  exp_s;
  logic [SP_FRAC_W-1:0] frac_s;
  logic [LZ_W-1:0]      lz;
  logic                 found;
  logic [SP_FRAC_W-1:0] frac_n;
  logic [DP_EXP_W-1:0]  exp_d;

  assign sgn    = sp_i[SP_W-1];
  assign exp_s  = sp_i[SP_W-2 -: SP_EXP_W];
  assign frac_s = sp_i[SP_FRAC_W-1:0];

  // leading-zero count for subnormal normalisation
  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = SP_FRAC_W - 1; i >= 0; i--) begin
      if (!found && frac_s[i]) begin
        lz    = LZ_W'(SP_FRAC_W - 1 - i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    frac_n = frac_s << (lz + LZ_W'(1));
    exp_d  = DP_EXP_W'(BIAS_DIFF) - DP_EXP_W'(lz);
    if (exp_s == '0) begin
      if (frac_s == '0) dp_o = {sgn, {(DP_W-1){1'b0}}};
      else              dp_o = {sgn, exp_d, frac_n, {FRAC_PAD_W{1'b0}}};
    end else if (exp_s == '1) begin
      dp_o = {sgn, {DP_EXP_W{1'b1}}, frac_s, {FRAC_PAD_W{1'b0}}};
    end else begin
      dp_o = {sgn, DP_EXP_W'(exp_s) + DP_EXP_W'(BIAS_DIFF), frac_s, {FRAC_PAD_W{1'b0}}};
    end
  end
endmodule

// File: rtl/fli_dp2sp.sv
module fli_dp2sp
  import fli_pkg::*;
(
  input  logic [DP_W-1:0] dp_i,
  output logic [SP_W-1:0] sp_o
);
  localparam int MIN_NORM_E = BIAS_DIFF + 1;
  localparam int MAX_NORM_E = BIAS_DIFF + (1 << SP_EXP_W) - 2;
  localparam int MIN_SUB_E  = BIAS_DIFF + 1 - SP_FRAC_W;

  logic                 sgn;
  logic [DP_EXP_W-1:0]  exp_d;
  logic [DP_FRAC_W-1:0] frac_d;
  logic [SP_FRAC_W-1:0] frac_hi;
  logic [SP_FRAC_W:0]   mant;
  logic [DP_EXP_W-1:0]  sh;
  logic [SP_FRAC_W-1:0] frac_sub;

  assign sgn     = dp_i[DP_W-1];
  assign exp_d   = dp_i[DP_W-2 -: DP_EXP_W];
  assign frac_d  = dp_i[DP_FRAC_W-1:0];
  assign frac_hi = frac_d[DP_FRAC_W-1 -: SP_FRAC_W];
  assign mant    = {1'b1, frac_hi};
  assign sh      = DP_EXP_W'(MIN_NORM_E) - exp_d;
  assign frac_sub = SP_FRAC_W'(mant >> sh[4:0]);

  always_comb begin
    if (exp_d == '1) begin
      // keep NaN a NaN when its payload lives only in dropped bits
      if (frac_d != '0 && frac_hi == '0)
        sp_o = {sgn, {SP_EXP_W{1'b1}}, 1'b1, {(SP_FRAC_W-1){1'b0}}};
      else
        sp_o = {sgn, {SP_EXP_W{1'b1}}, frac_hi};
    end else if (exp_d > DP_EXP_W'(MAX_NORM_E)) begin
      sp_o = {sgn, {SP_EXP_W{1'b1}}, {SP_FRAC_W{1'b0}}};
    end else if (exp_d >= DP_EXP_W'(MIN_NORM_E)) begin
      sp_o = {sgn, SP_EXP_W'(exp_d - DP_EXP_W'(BIAS_DIFF)), frac_hi};
    end else if (exp_d >= DP_EXP_W'(MIN_SUB_E)) begin
      sp_o = {sgn, {SP_EXP_W{1'b0}}, frac_sub};
    end else begin
      sp_o = {sgn, {(SP_W-1){1'b0}}};
    end
  end
endmodule

// File: rtl/fp_imm_loader.sv
module fp_imm_loader
  import fli_pkg::*;
#(
  parameter int HI_W  = 10,
  parameter int MID_W = 5,
  parameter int LO_W  = 1,
  localparam int IMM_W = HI_W + MID_W + LO_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             op_i,
  input  logic [HI_W-1:0]  imm_hi_i,
  input  logic [MID_W-1:0] imm_mid_i,
  input  logic [LO_W-1:0]  imm_lo_i,
  input  logic [DP_W-1:0]  reg_i,
  output logic [DP_W-1:0]  result_o,
  output logic             wr_en_o
);
  logic [IMM_W-1:0] imm;
  logic [SP_W-1:0]  cur_sp;
  logic [SP_W-1:0]  new_sp;
  logic [DP_W-1:0]  new_dp;
  logic [DP_W-1:0]  result_q;
  logic             wr_q;
  fli_op_e          op;

  assign op = fli_op_e'(op_i);

  fli_imm_join #(.HI_W(HI_W), .MID_W(MID_W), .LO_W(LO_W)) u_join (
    .hi_i (imm_hi_i),
    .mid_i(imm_mid_i),
    .lo_i (imm_lo_i),
    .imm_o(imm)
  );

  fli_dp2sp u_narrow (
    .dp_i(reg_i),
    .sp_o(cur_sp)
  );

  // one widening unit shared by both operations
  always_comb begin
    if (op == OP_INSERT) new_sp = {cur_sp[SP_W-1 -: HALF_W], imm};
    else                 new_sp = {imm, {HALF_W{1'b0}}};
  end

  fli_sp2dp u_widen (
    .sp_i(new_sp),
    .dp_o(new_dp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      wr_q     <= 1'b0;
    end else begin
      wr_q <= valid_i;
      if (valid_i) result_q <= new_dp;
    end
  end

  assign result_o = result_q;
  assign wr_en_o  = wr_q;

  // R8
  strobe_follows_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> wr_en_o);
  // R8
  strobe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !wr_en_o);
  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_o |-> $stable(result_o));
  // R2
  load_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_LOAD) |=> result_o[DP_W-1] == $past(imm[IMM_W-1]));
  // R3
  load_special_exp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_LOAD && imm[IMM_W-2 -: SP_EXP_W] == '1)
      |=> result_o[DP_W-2 -: DP_EXP_W] == '1);
  // R5
  insert_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_INSERT) |=> result_o[DP_W-1] == $past(reg_i[DP_W-1]));
endmodule

// File: tb/tb_fp_imm_loader.sv
module tb_fp_imm_loader;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        op_i = 1'b0;
  logic [9:0]  imm_hi_i = '0;
  logic [4:0]  imm_mid_i = '0;
  logic [0:0]  imm_lo_i = '0;
  logic [63:0] reg_i = '0;
  logic [63:0] result_o;
  logic        wr_en_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  fp_imm_loader dut (
    .clk_i, .rst_ni, .valid_i, .op_i, .imm_hi_i, .imm_mid_i, .imm_lo_i,
    .reg_i, .result_o, .wr_en_o
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic op, input logic [15:0] imm, input logic [63:0] r);
    op_i      = op;
    imm_hi_i  = imm[15:6];
    imm_mid_i = imm[5:1];
    imm_lo_i  = imm[0];
    reg_i     = r;
    valid_i   = 1'b1;
  endtask

  // single op: drive at negedge, sample at the negedge after the capturing edge
  task automatic one_op(input string req, input logic op, input logic [15:0] imm,
                        input logic [63:0] r, input logic [63:0] exp);
    @(negedge clk_i);
    drive(op, imm, r);
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(req, result_o, exp);
    chk({req, " strobe"}, {63'd0, wr_en_o}, 64'd1);
  endtask

  task automatic t_reset;
    chk("R8 reset result", result_o, 64'd0);
    chk("R8 reset strobe", {63'd0, wr_en_o}, 64'd0);
  endtask

  task automatic t_load_consts;
    one_op("R2 +0.0", 1'b0, 16'h0000, 64'h0, 64'h0000000000000000);
    one_op("R2 -0.0", 1'b0, 16'h8000, 64'h0, 64'h8000000000000000);
    one_op("R2 +1.0", 1'b0, 16'h3F80, 64'h0, 64'h3FF0000000000000);
    one_op("R2 -1.0", 1'b0, 16'hBF80, 64'h0, 64'hBFF0000000000000);
    one_op("R2 -1.5", 1'b0, 16'hBFC0, 64'h0, 64'hBFF8000000000000);
    one_op("R1 R2 1.9921875", 1'b0, 16'h3FFF, 64'h0, 64'h3FFFE00000000000);
  endtask

  task automatic t_load_special;
    one_op("R3 +inf", 1'b0, 16'h7F80, 64'h0, 64'h7FF0000000000000);
    one_op("R3 -inf", 1'b0, 16'hFF80, 64'h0, 64'hFFF0000000000000);
    one_op("R3 qnan", 1'b0, 16'h7FC0, 64'h0, 64'h7FF8000000000000);
  endtask

  task automatic t_subnormal;
    one_op("R1 R4 lo field", 1'b0, 16'h0001, 64'h0, 64'h37A0000000000000);
    one_op("R1 R4 mid field", 1'b0, 16'h0002, 64'h0, 64'h37B0000000000000);
    one_op("R4 neg subnormal", 1'b0, 16'h8040, 64'h0, 64'hB800000000000000);
  endtask

  task automatic t_insert;
    one_op("R5 insert", 1'b1, 16'h8000, 64'h3FF0000000000000, 64'h3FF0100000000000);
    one_op("R6 truncate", 1'b1, 16'h0000, 64'h3FF0000000000001, 64'h3FF0000000000000);
    one_op("R6 overflow", 1'b1, 16'h0001, 64'h7FE0000000000000, 64'h7FF0000020000000);
    one_op("R6 underflow", 1'b1, 16'h1234, 64'h0010000000000000, 64'h3762340000000000);
    one_op("R7 nan keep", 1'b1, 16'h0000, 64'h7FF0000000000001, 64'h7FF8000000000000);
  endtask

  task automatic t_back_to_back;
    logic [63:0] held;
    @(negedge clk_i);
    drive(1'b0, 16'h3F80, 64'h0);
    @(negedge clk_i);
    chk("R9 first result", result_o, 64'h3FF0000000000000);
    chk("R9 first strobe", {63'd0, wr_en_o}, 64'd1);
    drive(1'b1, 16'h8000, result_o);
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R9 combined", result_o, 64'h3FF0100000000000);
    chk("R9 second strobe", {63'd0, wr_en_o}, 64'd1);
    held = result_o;
    @(negedge clk_i);
    chk("R8 strobe drops", {63'd0, wr_en_o}, 64'd0);
    chk("R8 result held", result_o, held);
    drive(1'b0, 16'hFF80, 64'h0);
    valid_i = 1'b0;
    @(negedge clk_i);
    chk("R8 idle ignores inputs", result_o, held);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_load_consts();
    t_load_special();
    t_subnormal();
    t_insert();
    t_back_to_back();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule